// File: doc/BRIEF.md
# Automatic RTS Flow Controller

This block decides the level of the active-low request-to-send pin of a serial receiver. It watches the receive FIFO and pulls the pin high (inactive) in time to pause the remote transmitter before the FIFO can overflow. Its inputs are the current FIFO fill count, a two-bit trigger select, a pulse from the serial receiver marking the moment the first data bit of an incoming character has been sampled, the host read strobe on the receive data register, and two modem-control bits. The first of those bits is a software RTS request. The second enables flow control.

Flow control is automatic only when both control bits are set. When the enable bit is clear, the pin simply mirrors the inverse of the software request. When the enable is set but the request is clear, the transmit side uses automatic CTS while RTS stays inactive.

In automatic mode the release and restore points depend on the trigger select. The shallow triggers (1, 4 and 8 characters) pause at the trigger level and resume only once the FIFO has been drained to empty. The deep trigger pauses as the last free slot starts filling and resumes as soon as a read frees a slot.

Top module: `auto_rts_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, `rts_n` is 1 (inactive).
- R2: With `mcr_flow_en` = 0, `rts_n` equals the inverse of `mcr_rts_req` from the previous cycle, whatever the other inputs are.
- R3: With `mcr_flow_en` = 1 and `mcr_rts_req` = 0, `rts_n` is 1 in the next cycle.
- R4: In automatic mode with a shallow trigger, `rts_n` becomes 1 in the cycle after `fifo_level` is at least the trigger count. The trigger select encodes 0 as 1 character, 1 as 4 characters and 2 as 8 characters.
- R5: In automatic mode with a shallow trigger, once paused, `rts_n` stays 1 while `fifo_level` is nonzero, even below the trigger count. It returns to 0 in the cycle after `fifo_level` is 0.
- R6: In automatic mode with the deep trigger (select 3), `rts_n` becomes 1 in the cycle after `rx_first_bit` is high with `fifo_level` at least DEPTH-1 (15) and no `host_rd`.
- R7: With the deep trigger, `rts_n` is 0 in the cycle after `host_rd` is high. This holds even when `rx_first_bit` is high in the same cycle.
- R8: With the deep trigger and no pause in effect, the fill level alone never releases RTS: without `rx_first_bit`, or with `fifo_level` below DEPTH-1, `rts_n` stays 0.
- R9: Leaving automatic mode clears any pause. On re-entry, RTS is active again unless a pause condition is met anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_level | input | LVL_W | Characters currently held in the receive FIFO (0..DEPTH) |
| trig_sel | input | 2 | Receive trigger select: 0=1, 1=4, 2=8, 3=deep |
| rx_first_bit | input | 1 | Pulse: first data bit of an incoming character sampled |
| host_rd | input | 1 | Pulse: host read of the receive data register |
| mcr_rts_req | input | 1 | Software RTS request bit |
| mcr_flow_en | input | 1 | Flow-control enable bit |
| rts_n | output | 1 | Registered active-low RTS pin |

## Verification
The in-RTL properties check the per-cycle rules on every cycle: the reset value, mirroring of the request bit in manual mode, forced inactivity in CTS-only mode, the set condition for each trigger class, read-wins release in deep mode, and pause clearing on leaving automatic mode. The hysteresis as a sequence can only be shown by the bench scenarios. That sequence is: pause at a threshold, stay paused while the level drops below it, and release exactly at empty. The same applies to pause state carried across trigger-select changes and mode exits, which the random stream and directed sequences reach while a reference model tracks the expected pin.

// File: rtl/rtsfc_pkg.sv
package rtsfc_pkg;
  typedef enum logic [1:0] {
    FC_MANUAL   = 2'd0,
    FC_CTS_ONLY = 2'd1,
    FC_AUTO     = 2'd2
  } fc_mode_e;

  typedef enum logic [1:0] {
    TRG_ONE   = 2'd0,
    TRG_FOUR  = 2'd1,
    TRG_EIGHT = 2'd2,
    TRG_DEEP  = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rtsfc_mode_dec.sv
module rtsfc_mode_dec
  import rtsfc_pkg::*;
(
  input  logic     rts_req,
  input  logic     flow_en,
  output fc_mode_e mode
);
  always_comb begin
    if (!flow_en)     mode = FC_MANUAL;
    else if (rts_req) mode = FC_AUTO;
    else              mode = FC_CTS_ONLY;
  end
endmodule

// File: rtl/rtsfc_trig_dec.sv
module rtsfc_trig_dec
  import rtsfc_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TRIG_LO  = 1,
  parameter int TRIG_MID = 4,
  parameter int TRIG_HI  = 8
) (
  input  logic [1:0]       trig_sel,
  output logic [LVL_W-1:0] thresh,
  output logic             deep
);
  always_comb begin
    deep   = 1'b0;
    thresh = LVL_W'(TRIG_LO);
    case (trig_sel_e'(trig_sel))
      TRG_ONE:   thresh = LVL_W'(TRIG_LO);
      TRG_FOUR:  thresh = LVL_W'(TRIG_MID);
      TRG_EIGHT: thresh = LVL_W'(TRIG_HI);
      default:   deep   = 1'b1;
    endcase
  end
endmodule

// File: rtl/rtsfc_hyst.sv
module rtsfc_hyst #(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_on,
  input  logic             deep,
  input  logic [LVL_W-1:0] thresh,
  input  logic [LVL_W-1:0] level,
  input  logic             first_bit,
  input  logic             host_rd,
  output logic             paused_d,
  output logic             paused_q
);
  localparam logic [LVL_W-1:0] DEEP_MARK = LVL_W'(DEPTH - 1);

  always_comb begin
    paused_d = paused_q;
    if (!auto_on) begin
      paused_d = 1'b0;
    end else if (deep) begin
      // a read frees a slot, so it wins over an arriving character
      if (host_rd)                              paused_d = 1'b0;
      else if (first_bit && level >= DEEP_MARK) paused_d = 1'b1;
    end else begin
      if (level == '0)          paused_d = 1'b0;
      else if (level >= thresh) paused_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) paused_q <= 1'b0;
    else     paused_q <= paused_d;
  end

  p_shallow_set_r4: assert property (@(posedge clk) disable iff (rst)
    auto_on && !deep && level >= thresh |=> paused_q);
  p_shallow_hold_r5: assert property (@(posedge clk) disable iff (rst)
    auto_on && !deep && paused_q && level != '0 |=> paused_q);
  p_deep_set_r6: assert property (@(posedge clk) disable iff (rst)
    auto_on && deep && first_bit && !host_rd && level >= DEEP_MARK |=> paused_q);
  p_deep_read_r7: assert property (@(posedge clk) disable iff (rst)
    auto_on && deep && host_rd |=> !paused_q);
  p_deep_no_level_r8: assert property (@(posedge clk) disable iff (rst)
    auto_on && deep && !paused_q && !first_bit |=> !paused_q);
  p_exit_clears_r9: assert property (@(posedge clk) disable iff (rst)
    !auto_on |=> !paused_q);
endmodule

// File: rtl/auto_rts_ctrl.sv
module auto_rts_ctrl
  import rtsfc_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TRIG_LO  = 1,
  parameter int TRIG_MID = 4,
  parameter int TRIG_HI  = 8,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       trig_sel,
  input  logic             rx_first_bit,
  input  logic             host_rd,
  input  logic             mcr_rts_req,
  input  logic             mcr_flow_en,
  output logic             rts_n
);
  fc_mode_e         mode;
  logic [LVL_W-1:0] thresh;
  logic             deep;
  logic             paused_d;
  logic             paused_q;
  logic             auto_on;

  rtsfc_mode_dec u_mode (
    .rts_req (mcr_rts_req),
    .flow_en (mcr_flow_en),
    .mode    (mode)
  );

  rtsfc_trig_dec #(
    .LVL_W   (LVL_W),
    .TRIG_LO (TRIG_LO),
    .TRIG_MID(TRIG_MID),
    .TRIG_HI (TRIG_HI)
  ) u_trig (
    .trig_sel(trig_sel),
    .thresh  (thresh),
    .deep    (deep)
  );

  assign auto_on = (mode == FC_AUTO);

  rtsfc_hyst #(
    .DEPTH(DEPTH),
    .LVL_W(LVL_W)
  ) u_hyst (
    .clk      (clk),
    .rst      (rst),
    .auto_on  (auto_on),
    .deep     (deep),
    .thresh   (thresh),
    .level    (fifo_level),
    .first_bit(rx_first_bit),
    .host_rd  (host_rd),
    .paused_d (paused_d),
    .paused_q (paused_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b1;
    end else begin
      case (mode)
        FC_AUTO:     rts_n <= paused_d;
        FC_CTS_ONLY: rts_n <= 1'b1;
        default:     rts_n <= ~mcr_rts_req;
      endcase
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> rts_n);
  p_manual_mirror_r2: assert property (@(posedge clk) disable iff (rst)
    !mcr_flow_en |=> rts_n == !$past(mcr_rts_req));
  p_cts_only_r3: assert property (@(posedge clk) disable iff (rst)
    mcr_flow_en && !mcr_rts_req |=> rts_n);
  p_auto_pin_r5: assert property (@(posedge clk) disable iff (rst)
    auto_on |=> rts_n == paused_q);
endmodule

// File: tb/auto_rts_ctrl_tb_top.sv
`timescale 1ns/1ps
module auto_rts_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [1:0]       trig_sel = '0;
  logic             rx_first_bit = 1'b0;
  logic             host_rd = 1'b0;
  logic             mcr_rts_req = 1'b0;
  logic             mcr_flow_en = 1'b0;
  logic             rts_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit m_paused = 1'b0;

  always #4 clk = ~clk;

  auto_rts_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .fifo_level(fifo_level), .trig_sel(trig_sel),
    .rx_first_bit(rx_first_bit), .host_rd(host_rd),
    .mcr_rts_req(mcr_rts_req), .mcr_flow_en(mcr_flow_en), .rts_n(rts_n)
  );

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic bit next_pause(input bit p, input bit auto, input logic [1:0] s,
                                    input int lvl, input bit fb, input bit rd);
    if (!auto) return 1'b0;
    if (s == 2'd3) begin
      if (rd) return 1'b0;
      if (fb && lvl >= DEPTH - 1) return 1'b1;
      return p;
    end
    if (lvl == 0) return 1'b0;
    if (lvl >= thr_of(s)) return 1'b1;
    return p;
  endfunction

  function automatic string tag_of(input bit fen, input bit req, input logic [1:0] s,
                                   input int lvl, input bit fb, input bit rd);
    if (!fen) return "R2";
    if (!req) return "R3";
    if (s == 2'd3) begin
      if (rd) return "R7";
      if (fb && lvl >= DEPTH - 1) return "R6";
      return "R8";
    end
    if (lvl >= thr_of(s)) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rts_n=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    check(rts_n, 1'b1, "R1");
    @(negedge clk);
    rst = 1'b0;
    m_paused = 1'b0;
    check(rts_n, 1'b1, "R1");
  endtask

  task automatic apply(input bit fen, input bit req, input logic [1:0] s,
                       input int lvl, input bit fb, input bit rd, input string force_tag);
    bit auto;
    bit exp;
    string tag;
    mcr_flow_en = fen; mcr_rts_req = req; trig_sel = s;
    fifo_level = LVL_W'(lvl); rx_first_bit = fb; host_rd = rd;
    auto = fen && req;
    m_paused = next_pause(m_paused, auto, s, lvl, fb, rd);
    exp = auto ? m_paused : !req;
    tag = (force_tag.len() != 0) ? force_tag : tag_of(fen, req, s, lvl, fb, rd);
    @(negedge clk);
    check(rts_n, exp, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R2 manual mirror
    apply(0, 1, 2'd0, 16, 1, 0, "R2");
    apply(0, 0, 2'd3, 15, 1, 0, "R2");
    apply(0, 1, 2'd1, 0, 0, 1, "R2");
    // R3 CTS-only mode
    apply(1, 0, 2'd0, 5, 0, 0, "R3");
    apply(1, 0, 2'd3, 0, 0, 0, "R3");
    // R4 / R5 shallow hysteresis with trigger 4
    apply(1, 1, 2'd1, 3, 0, 0, "R4");
    apply(1, 1, 2'd1, 4, 0, 0, "R4");
    apply(1, 1, 2'd1, 2, 0, 1, "R5");
    apply(1, 1, 2'd1, 1, 0, 1, "R5");
    apply(1, 1, 2'd1, 0, 0, 0, "R5");
    apply(1, 1, 2'd2, 7, 0, 0, "R4");
    apply(1, 1, 2'd2, 8, 0, 0, "R4");
    apply(1, 1, 2'd0, 0, 0, 0, "R5");
    apply(1, 1, 2'd0, 1, 0, 0, "R4");
    apply(1, 1, 2'd0, 0, 0, 0, "R5");
    // R6 / R7 / R8 deep trigger
    apply(1, 1, 2'd3, 14, 1, 0, "R8");
    apply(1, 1, 2'd3, 16, 0, 0, "R8");
    apply(1, 1, 2'd3, 15, 1, 0, "R6");
    apply(1, 1, 2'd3, 16, 0, 0, "R6");
    apply(1, 1, 2'd3, 16, 0, 1, "R7");
    apply(1, 1, 2'd3, 15, 1, 1, "R7");
    apply(1, 1, 2'd3, 15, 1, 0, "R6");
    apply(1, 1, 2'd3, 15, 0, 1, "R7");
    // R9 leaving auto clears a shallow pause
    apply(1, 1, 2'd0, 1, 0, 0, "R9");
    apply(1, 0, 2'd2, 2, 0, 0, "R9");
    apply(1, 1, 2'd2, 2, 0, 0, "R9");
    apply(1, 1, 2'd0, 3, 0, 0, "R9");
    apply(0, 1, 2'd0, 3, 0, 0, "R9");
    apply(1, 1, 2'd3, 3, 0, 0, "R9");

    for (int i = 0; i < 4000; i++) begin
      int lvl;
      int pick;
      bit fen, req;
      pick = $urandom_range(0, 9);
      fen = ($urandom_range(0, 9) != 0);
      req = ($urandom_range(0, 9) != 0);
      if (pick < 6) begin
        case ($urandom_range(0, 9))
          0: lvl = 0; 1: lvl = 1; 2: lvl = 3; 3: lvl = 4; 4: lvl = 7;
          5: lvl = 8; 6: lvl = 14; 7: lvl = 15; default: lvl = 16;
        endcase
      end else begin
        lvl = $urandom_range(0, DEPTH);
      end
      if (i == 2000) do_reset();
      apply(fen, req, 2'($urandom_range(0, 3)), lvl,
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0), "");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule